// File: doc/BRIEF.md
# Processor Idle Phase Sequencer

This block walks one processor core through a low-power idle sequence. It starts from normal execution. If the selected state asks for it, the core passes through a preparation phase that can still be called off. It then enters a committed entry phase and an idle phase of any length, and finally an exit phase that brings it back to execution.

The caller raises an idle request together with a state index. A per-state descriptor table, supplied on input ports, gives four things for each state:

- the entry duration, in whole microseconds;
- the exit duration, in whole microseconds;
- whether the state uses the abortable preparation phase;
- whether the state loses the core's local timer.

An external engine, such as a cache flush engine, signals the end of preparation. A wake-up line ends the idle phase. The block takes its microsecond time base from a prescaler sized by a clock-frequency parameter.

As the sequence runs, the block reports:

- the current phase;
- whether the core is committed;
- whether the local timer is lost;
- a live estimate of the remaining wake-up delay, in microseconds.

A scheduler can use the delay estimate to pick the core that is cheapest to wake. Requests that arrive while a sequence is already running are refused, and a one-cycle flag reports each refusal.

Top module: `idle_phase_seq`

## Requirements
- R1: The phase output uses the codes EXEC=0, PREP=1, ENTRY=2, IDLE=3, EXIT=4. An idle request seen in EXEC moves the core, one cycle later, to PREP if bit `idle_sel` of `prep_en_tbl` is 1, and to ENTRY otherwise. IDLE is reached only from ENTRY.
- R2: In PREP, a wake-up returns the core to EXEC on the next cycle, and it takes priority over `prep_done`. Without a wake-up, `prep_done` moves the core to ENTRY on the next cycle. With neither input, the core stays in PREP.
- R3: ENTRY lasts exactly L×DIV clock cycles, where L is the selected entry duration and DIV is the number of clock cycles per microsecond. When L=0 it lasts one cycle. ENTRY always ends in IDLE, whatever happens on the wake-up line.
- R4: A wake-up pulse seen during ENTRY is remembered. The core then spends one cycle in IDLE and moves to EXIT.
- R5: With no pending wake-up, IDLE holds for as long as the wake-up line stays low. A wake-up in IDLE moves the core to EXIT on the next cycle.
- R6: EXIT lasts exactly X×DIV clock cycles, where X is the selected exit duration. When X=0 it lasts one cycle. EXIT then returns the core to EXEC.
- R7: `committed` is 1 exactly while the phase is ENTRY, IDLE or EXIT.
- R8: `wake_delay`, in microseconds, depends on the phase:
  - EXEC: 0.
  - PREP: entry plus exit duration.
  - ENTRY: exit duration plus the whole microseconds of entry still to run. This value never grows during ENTRY and drops by one each DIV cycles.
  - IDLE: the exit duration.
  - EXIT: the whole microseconds of exit still to run.
- R9: `timer_lost` is 1 in every phase other than EXEC when the selected state has its bit set in `timer_loss_tbl`. It is 0 in EXEC.
- R10: An idle request made outside EXEC has no effect on the phase or on the running sequence. `req_rejected` is 1 for exactly the one cycle after each such request.
- R11: While reset is low at a clock edge, the block returns to EXEC with `committed`, `timer_lost`, `wake_delay` and `req_rejected` all at 0. This holds even in the middle of a sequence.
- R12: The descriptor of the selected state is captured when the request is accepted. Later changes to the table do not alter a sequence already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_req | input | 1 | Request to start an idle sequence |
| idle_sel | input | SEL_W | Index of the idle state to enter |
| wake | input | 1 | Wake-up event |
| prep_done | input | 1 | Preparation work finished |
| entry_us_tbl | input | N_STATES×DUR_W | Entry durations, state k in slice k |
| exit_us_tbl | input | N_STATES×DUR_W | Exit durations, state k in slice k |
| prep_en_tbl | input | N_STATES | Bit k: state k uses the preparation phase |
| timer_loss_tbl | input | N_STATES | Bit k: state k loses the local timer |
| phase | output | 3 | Current phase code |
| committed | output | 1 | Core committed to idle |
| timer_lost | output | 1 | Local timer state lost |
| wake_delay | output | DUR_W+1 | Remaining wake-up delay in microseconds |
| req_rejected | output | 1 | One-cycle flag for a refused request |

## Verification
Each internal fault shows up at the ports, most of them at once:

- A wrong remaining-time count appears on `wake_delay` in the same cycle. During ENTRY, a count that decrements at the wrong time makes the estimate differ from the bench's expected value at the first tick boundary, four cycles into the phase.
- A wrong phase register appears at once on `phase` and `committed`.
- A lost or stale pending-wake flag shows as an IDLE phase that never ends, or one that ends without a wake-up, within one cycle of leaving ENTRY.
- A prescaler that is not restarted at each phase change shifts the length of every ENTRY and EXIT by up to DIV−1 cycles. The length checks catch this at the end of the affected phase.

// File: rtl/idle_seq_pkg.sv
// Shared types for the idle phase sequencer.
// Assumes: phase codes are observed at the top-level ports, so their values are fixed.
package idle_seq_pkg;

    typedef enum logic [2:0] {
        PH_EXEC  = 3'd0,
        PH_PREP  = 3'd1,
        PH_ENTRY = 3'd2,
        PH_IDLE  = 3'd3,
        PH_EXIT  = 3'd4
    } phase_e;

    // True for the phases where the hardware can no longer back out.
    function automatic logic is_committed(phase_e p);
        return (p == PH_ENTRY) || (p == PH_IDLE) || (p == PH_EXIT);
    endfunction

endpackage

// File: rtl/idle_tick_div.sv
// Microsecond tick prescaler.
// Produces a one-cycle pulse every DIV clock cycles, with DIV = CLK_FREQ_HZ / TICK_HZ
// (at least 1). The restart input resets the count, so a new phase always sees its
// first tick exactly DIV cycles after it begins.
// Assumes: CLK_FREQ_HZ is an integer multiple of TICK_HZ.
module idle_tick_div #(
    parameter int CLK_FREQ_HZ = 200_000_000,
    parameter int TICK_HZ     = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DIV_RAW = CLK_FREQ_HZ / TICK_HZ;
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int CW      = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Tick is raised during the last cycle of each DIV-cycle window.
    assign tick = (cnt_q == CW'(DIV - 1));

    // Count cycles within the current window; clear on restart or on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/idle_state_table.sv
// Descriptor selector.
// Unpacks the flat per-state vectors and returns the descriptor of the indexed
// state. An index beyond N_STATES returns an all-zero descriptor.
// Assumes: slice k of each flat vector belongs to state k.
module idle_state_table #(
    parameter int N_STATES = 4,
    parameter int DUR_W    = 12,
    parameter int SEL_W    = 2
) (
    input  logic [N_STATES*DUR_W-1:0] entry_flat,
    input  logic [N_STATES*DUR_W-1:0] exit_flat,
    input  logic [N_STATES-1:0]       prep_bits,
    input  logic [N_STATES-1:0]       loss_bits,
    input  logic [SEL_W-1:0]          sel,
    output logic [DUR_W-1:0]          sel_entry,
    output logic [DUR_W-1:0]          sel_exit,
    output logic                      sel_prep,
    output logic                      sel_loss
);
    logic [DUR_W-1:0] entry_arr [N_STATES];
    logic [DUR_W-1:0] exit_arr  [N_STATES];

    for (genvar k = 0; k < N_STATES; k++) begin : g_unpack
        assign entry_arr[k] = entry_flat[k*DUR_W +: DUR_W];
        assign exit_arr[k]  = exit_flat[k*DUR_W +: DUR_W];
    end

    // Pick the selected state's fields, or zeros for an index beyond the table.
    always_comb begin
        sel_entry = '0;
        sel_exit  = '0;
        sel_prep  = 1'b0;
        sel_loss  = 1'b0;
        if (int'(sel) < N_STATES) begin
            sel_entry = entry_arr[sel];
            sel_exit  = exit_arr[sel];
            sel_prep  = prep_bits[sel];
            sel_loss  = loss_bits[sel];
        end
    end
endmodule

// File: rtl/idle_phase_ctrl.sv
// Phase state machine with its microsecond down-counter.
// Moves EXEC -> [PREP] -> ENTRY -> IDLE -> EXIT -> EXEC.
// - PREP can be abandoned by a wake-up; ENTRY cannot.
// - A wake-up seen during ENTRY is held and ends IDLE after one cycle.
// - The descriptor is captured when the request is accepted.
// Assumes: tick comes from a prescaler that restarts whenever restart is high.
module idle_phase_ctrl
    import idle_seq_pkg::*;
#(
    parameter int DUR_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             idle_req,
    input  logic             wake,
    input  logic             prep_done,
    input  logic [DUR_W-1:0] sel_entry,
    input  logic [DUR_W-1:0] sel_exit,
    input  logic             sel_prep,
    input  logic             sel_loss,
    output phase_e           phase_q,
    output logic             restart,
    output logic [DUR_W-1:0] rem_q,
    output logic [DUR_W-1:0] entry_q,
    output logic [DUR_W-1:0] exit_q,
    output logic             loss_q,
    output logic             rejected_q
);
    phase_e phase_d;
    logic   pend_q;
    logic   rem_done;

    // A timed phase ends on a zero count or on the tick that consumes the last microsecond.
    assign rem_done = (rem_q == '0) || (tick && (rem_q == DUR_W'(1)));

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_EXEC:  if (idle_req) phase_d = sel_prep ? PH_PREP : PH_ENTRY;
            PH_PREP:  if (wake) phase_d = PH_EXEC;
                      else if (prep_done) phase_d = PH_ENTRY;
            PH_ENTRY: if (rem_done) phase_d = PH_IDLE;
            PH_IDLE:  if (wake || pend_q) phase_d = PH_EXIT;
            PH_EXIT:  if (rem_done) phase_d = PH_EXEC;
            default:  phase_d = PH_EXEC;
        endcase
    end

    assign restart = (phase_d != phase_q);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_EXEC;
        else        phase_q <= phase_d;
    end

    // Capture the selected descriptor when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= '0;
            exit_q  <= '0;
            loss_q  <= 1'b0;
        end else if (phase_q == PH_EXEC && idle_req) begin
            entry_q <= sel_entry;
            exit_q  <= sel_exit;
            loss_q  <= sel_loss;
        end
    end

    // Remaining microseconds of the current timed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (phase_d == PH_ENTRY && phase_q != PH_ENTRY) begin
            rem_q <= (phase_q == PH_EXEC) ? sel_entry : entry_q;
        end else if (phase_d == PH_EXIT && phase_q != PH_EXIT) begin
            rem_q <= exit_q;
        end else if ((phase_q == PH_ENTRY || phase_q == PH_EXIT) && tick && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    // Hold a wake-up that arrives while the core is committed to entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (phase_d == PH_EXIT) pend_q <= 1'b0;
        else if (phase_q == PH_ENTRY && wake) pend_q <= 1'b1;
    end

    // Flag a request that arrives while a sequence is already running.
    always_ff @(posedge clk) begin
        if (!rst_n) rejected_q <= 1'b0;
        else        rejected_q <= idle_req && (phase_q != PH_EXEC);
    end
endmodule

// File: rtl/idle_wake_est.sv
// Live wake-up delay estimate in microseconds: exit time, plus whatever part of the
// entry time has not yet run out.
// Assumes: rem is the down-counter of the running timed phase; entry and exit are the
// captured descriptor values.
module idle_wake_est
    import idle_seq_pkg::*;
#(
    parameter int DUR_W = 12
) (
    input  phase_e           phase,
    input  logic [DUR_W-1:0] rem,
    input  logic [DUR_W-1:0] entry_dur,
    input  logic [DUR_W-1:0] exit_dur,
    output logic [DUR_W:0]   delay
);
    // Per-phase delay formula; the extra bit keeps the sum from overflowing.
    always_comb begin
        case (phase)
            PH_PREP:  delay = {1'b0, entry_dur} + {1'b0, exit_dur};
            PH_ENTRY: delay = {1'b0, exit_dur} + {1'b0, rem};
            PH_IDLE:  delay = {1'b0, exit_dur};
            PH_EXIT:  delay = {1'b0, rem};
            default:  delay = '0;
        endcase
    end
endmodule

// File: rtl/idle_phase_seq.sv
// Top level of the per-core idle phase sequencer.
// Ties together the descriptor selector, the microsecond prescaler, the phase
// controller and the wake-delay estimator.
// Assumes: one instance per core; wake and prep_done are synchronous to clk.
module idle_phase_seq
    import idle_seq_pkg::*;
#(
    parameter int N_STATES    = 4,
    parameter int DUR_W       = 12,
    parameter int CLK_FREQ_HZ = 200_000_000,
    localparam int SEL_W      = (N_STATES > 1) ? $clog2(N_STATES) : 1,
    localparam int DLY_W      = DUR_W + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      idle_req,
    input  logic [SEL_W-1:0]          idle_sel,
    input  logic                      wake,
    input  logic                      prep_done,
    input  logic [N_STATES*DUR_W-1:0] entry_us_tbl,
    input  logic [N_STATES*DUR_W-1:0] exit_us_tbl,
    input  logic [N_STATES-1:0]       prep_en_tbl,
    input  logic [N_STATES-1:0]       timer_loss_tbl,
    output logic [2:0]                phase,
    output logic                      committed,
    output logic                      timer_lost,
    output logic [DLY_W-1:0]          wake_delay,
    output logic                      req_rejected
);
    logic [DUR_W-1:0] sel_entry, sel_exit;
    logic             sel_prep, sel_loss;
    logic             tick, restart;
    phase_e           ph;
    logic [DUR_W-1:0] rem, entry_q, exit_q;
    logic             loss_q;

    idle_state_table #(
        .N_STATES(N_STATES), .DUR_W(DUR_W), .SEL_W(SEL_W)
    ) u_table (
        .entry_flat(entry_us_tbl),
        .exit_flat (exit_us_tbl),
        .prep_bits (prep_en_tbl),
        .loss_bits (timer_loss_tbl),
        .sel       (idle_sel),
        .sel_entry (sel_entry),
        .sel_exit  (sel_exit),
        .sel_prep  (sel_prep),
        .sel_loss  (sel_loss)
    );

    idle_tick_div #(
        .CLK_FREQ_HZ(CLK_FREQ_HZ), .TICK_HZ(1_000_000)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .tick   (tick)
    );

    idle_phase_ctrl #(
        .DUR_W(DUR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .idle_req  (idle_req),
        .wake      (wake),
        .prep_done (prep_done),
        .sel_entry (sel_entry),
        .sel_exit  (sel_exit),
        .sel_prep  (sel_prep),
        .sel_loss  (sel_loss),
        .phase_q   (ph),
        .restart   (restart),
        .rem_q     (rem),
        .entry_q   (entry_q),
        .exit_q    (exit_q),
        .loss_q    (loss_q),
        .rejected_q(req_rejected)
    );

    idle_wake_est #(
        .DUR_W(DUR_W)
    ) u_est (
        .phase    (ph),
        .rem      (rem),
        .entry_dur(entry_q),
        .exit_dur (exit_q),
        .delay    (wake_delay)
    );

    assign phase      = ph;
    assign committed  = is_committed(ph);
    assign timer_lost = loss_q && (ph != PH_EXEC);
endmodule

// File: rtl/idle_phase_seq_chk.sv
// Property checker for idle_phase_seq, attached to every instance by the bind below.
// Assumes: synchronous active-low reset; the properties are idle until one clock
// edge after reset has been released.
module idle_phase_seq_chk #(
    parameter int W = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         idle_req,
    input logic         wake,
    input logic [2:0]   phase,
    input logic         timer_lost,
    input logic [W-1:0] wake_delay,
    input logic         req_rejected
);
    logic seen_q;

    // Marks that at least one post-reset cycle exists for $past.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    a_r1_idle_from_entry: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd3 && $past(phase) != 3'd3) |-> $past(phase) == 3'd2);

    a_r2_prep_abort: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd1 && wake) |=> phase == 3'd0);

    a_r3_entry_no_abort: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd2) |=> (phase == 3'd2 || phase == 3'd3));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd3 && $past(phase) == 3'd3 && !wake) |=> phase == 3'd3);

    a_r8_delay_shrinks: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd2 && $past(phase) == 3'd2) |-> wake_delay <= $past(wake_delay));

    a_r8_exec_zero: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd0) |-> wake_delay == '0);

    a_r9_timer_exec: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (phase == 3'd0) |-> !timer_lost);

    a_r10_reject_flag: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (idle_req && phase != 3'd0) |=> req_rejected);
endmodule

bind idle_phase_seq idle_phase_seq_chk #(.W(DUR_W + 1)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_req    (idle_req),
    .wake        (wake),
    .phase       (phase),
    .timer_lost  (timer_lost),
    .wake_delay  (wake_delay),
    .req_rejected(req_rejected)
);

// File: tb/idle_phase_seq_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of full sequences, then directed corner tests.
module idle_phase_seq_bench;
    localparam int NS   = 4;
    localparam int DW   = 8;
    localparam int FREQ = 4_000_000;
    localparam int DIV  = 4;

    // Bench copy of the descriptor table.
    localparam int ENT [NS] = '{2, 0, 5, 1};
    localparam int EXT [NS] = '{3, 1, 0, 2};
    localparam logic [NS-1:0] PREPB = 4'b0110;
    localparam logic [NS-1:0] LOSSB = 4'b0110;

    // Vector: sel[42:41], wake-in-entry[40], idle hold[39:32], ENTRY cycles[31:16], EXIT cycles[15:0]
    localparam int NV = 6;
    localparam logic [42:0] VECS [NV] = '{
        {2'd0, 1'b0, 8'd3, 16'd8,  16'd12},
        {2'd1, 1'b0, 8'd0, 16'd1,  16'd4},
        {2'd2, 1'b1, 8'd0, 16'd20, 16'd1},
        {2'd3, 1'b1, 8'd0, 16'd4,  16'd8},
        {2'd0, 1'b1, 8'd0, 16'd8,  16'd12},
        {2'd1, 1'b0, 8'd5, 16'd1,  16'd4}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic            idle_req = 1'b0;
    logic [1:0]      idle_sel = 2'd0;
    logic            wake = 1'b0;
    logic            prep_done = 1'b0;
    logic [NS*DW-1:0] entry_us_tbl = {8'd1, 8'd5, 8'd0, 8'd2};
    logic [NS*DW-1:0] exit_us_tbl  = {8'd2, 8'd0, 8'd1, 8'd3};
    logic [NS-1:0]   prep_en_tbl = PREPB;
    logic [NS-1:0]   timer_loss_tbl = LOSSB;
    logic [2:0]      phase;
    logic            committed, timer_lost, req_rejected;
    logic [DW:0]     wake_delay;

    int n_chk = 0;
    int n_fail = 0;

    idle_phase_seq #(.N_STATES(NS), .DUR_W(DW), .CLK_FREQ_HZ(FREQ)) u_idle_phase_seq (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_sel(idle_sel),
        .wake(wake), .prep_done(prep_done), .entry_us_tbl(entry_us_tbl),
        .exit_us_tbl(exit_us_tbl), .prep_en_tbl(prep_en_tbl),
        .timer_loss_tbl(timer_loss_tbl), .phase(phase), .committed(committed),
        .timer_lost(timer_lost), .wake_delay(wake_delay), .req_rejected(req_rejected)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(input int sel, input bit wk, input int hold,
                           input int exp_ent, input int exp_ext);
        int cnt;
        @(negedge clk);
        chk("R1 EXEC before request", int'(phase), 0);
        idle_req = 1'b1; idle_sel = 2'(sel);
        @(negedge clk);
        idle_req = 1'b0;
        chk("R1 first phase after request", int'(phase), PREPB[sel] ? 1 : 2);
        chk("R9 timer_lost after request", int'(timer_lost), int'(LOSSB[sel]));
        if (phase == 3'd1) begin
            chk("R8 delay in PREP", int'(wake_delay), ENT[sel] + EXT[sel]);
            chk("R7 not committed in PREP", int'(committed), 0);
            prep_done = 1'b1;
            @(negedge clk);
            prep_done = 1'b0;
            chk("R2 prep_done leads to ENTRY", int'(phase), 2);
        end
        chk("R8 delay at ENTRY start", int'(wake_delay), ENT[sel] + EXT[sel]);
        chk("R7 committed in ENTRY", int'(committed), 1);
        if (wk) wake = 1'b1;
        cnt = 0;
        while (phase == 3'd2 && cnt < 10000) begin
            cnt++;
            @(negedge clk);
            wake = 1'b0;
        end
        chk("R3 ENTRY length", cnt, exp_ent);
        chk("R3 ENTRY ends in IDLE", int'(phase), 3);
        chk("R8 delay in IDLE", int'(wake_delay), EXT[sel]);
        if (wk) begin
            @(negedge clk);
            chk("R4 latched wake leads to EXIT", int'(phase), 4);
        end else begin
            for (int i = 0; i < hold; i++) @(negedge clk);
            chk("R5 IDLE holds without wake", int'(phase), 3);
            wake = 1'b1;
            @(negedge clk);
            wake = 1'b0;
            chk("R5 wake leads to EXIT", int'(phase), 4);
        end
        chk("R8 delay at EXIT start", int'(wake_delay), EXT[sel]);
        cnt = 0;
        while (phase == 3'd4 && cnt < 10000) begin
            cnt++;
            @(negedge clk);
        end
        chk("R6 EXIT length", cnt, exp_ext);
        chk("R6 back in EXEC", int'(phase), 0);
        chk("R7 not committed in EXEC", int'(committed), 0);
        chk("R9 timer_lost clear in EXEC", int'(timer_lost), 0);
        chk("R8 delay zero in EXEC", int'(wake_delay), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        // R11: reset state, with a request held during reset.
        idle_req = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 phase in reset", int'(phase), 0);
        chk("R11 committed in reset", int'(committed), 0);
        chk("R11 timer_lost in reset", int'(timer_lost), 0);
        chk("R11 delay in reset", int'(wake_delay), 0);
        chk("R11 rejected in reset", int'(req_rejected), 0);
        idle_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_seq(int'(VECS[v][42:41]), VECS[v][40], int'(VECS[v][39:32]),
                    int'(VECS[v][31:16]), int'(VECS[v][15:0]));
        end

        // R2: wake and prep_done together in PREP, so the abort wins.
        idle_req = 1'b1; idle_sel = 2'd1;
        @(negedge clk);
        idle_req = 1'b0;
        chk("R2 in PREP", int'(phase), 1);
        chk("R9 timer_lost in PREP", int'(timer_lost), 1);
        wake = 1'b1; prep_done = 1'b1;
        @(negedge clk);
        wake = 1'b0; prep_done = 1'b0;
        chk("R2 wake aborts PREP", int'(phase), 0);
        chk("R9 timer_lost after abort", int'(timer_lost), 0);

        // R2 stall, then R10 and R12 during ENTRY of state 2 (5 us).
        idle_req = 1'b1; idle_sel = 2'd2;
        @(negedge clk);
        idle_req = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 PREP holds without prep_done", int'(phase), 1);
        prep_done = 1'b1;
        @(negedge clk);
        prep_done = 1'b0;
        cnt = 0;
        while (phase == 3'd2 && cnt < 10000) begin
            cnt++;
            if (cnt == 1) begin
                chk("R8 delay at ENTRY start state2", int'(wake_delay), 5);
                entry_us_tbl[2*DW +: DW] = 8'd1;
                idle_req = 1'b1; idle_sel = 2'd0;
            end
            if (cnt == 2) begin
                idle_req = 1'b0;
                chk("R10 rejected flag set", int'(req_rejected), 1);
                chk("R10 timer_lost kept for running state", int'(timer_lost), 1);
            end
            if (cnt == 3) chk("R10 rejected flag lasts one cycle", int'(req_rejected), 0);
            if (cnt == 5) chk("R8 delay after one tick", int'(wake_delay), 4);
            @(negedge clk);
        end
        chk("R12 ENTRY length unaffected by table change", cnt, 20);
        chk("R10 request ignored, ENTRY reached IDLE", int'(phase), 3);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        @(negedge clk);
        chk("R6 zero exit lasts one cycle", int'(phase), 0);
        entry_us_tbl[2*DW +: DW] = 8'd5;

        // R11: reset in the middle of IDLE.
        idle_req = 1'b1; idle_sel = 2'd0;
        @(negedge clk);
        idle_req = 1'b0;
        cnt = 0;
        while (phase != 3'd3 && cnt < 1000) begin cnt++; @(negedge clk); end
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 mid-sequence reset phase", int'(phase), 0);
        chk("R11 mid-sequence reset committed", int'(committed), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule